// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers five interrupt sources for an 8-bit CPU core: two active-low external pins, two timer overflow flags, and one serial source. The serial source is the OR of a receive flag and a transmit flag. Each source is gated by its own enable bit, and all of them are gated together by a global enable. Among the sources that survive both gates, a fixed order picks one. Its vector address is presented to the core together with a request strobe.

Each external pin has a trigger-type bit. With the bit at 0, the pin is level-sensitive and the request simply follows the pin while it is low. With the bit at 1, a falling edge is caught in a sticky flag, and that flag stays set until the core acknowledges the vector.

After an acknowledge, the block stays silent until the core pulses end-of-service. A two-entry register port gives access to the enable byte and to the trigger-type bits.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both register reads return 0x00 and `irq_req` is low.
- R2: While enable bit 7 (global gate) is 0, `irq_req` stays low whatever sources are pending and whatever the per-source enables hold.
- R3: Enable bits map to sources as follows: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. A source is taken only when its bit and bit 7 are both 1.
- R4: `irq_vec` is 0x0003, 0x000B, 0x0013, 0x001B or 0x0023 for external 0, timer 0, external 1, timer 1 and serial respectively, whenever `irq_req` is high.
- R5: The serial source is pending when `ser_rx_flag` or `ser_tx_flag` (or both) is 1.
- R6: With trigger bit n (read at `reg_sel`=1, bit n) at 0, external n requests in the same cycle its pin is low. It drops when the pin returns high and is not latched.
- R7: With trigger bit n at 1, a falling edge on `ext_n[n]` raises the request from the clock edge that samples the low pin. The request stays set after the pin goes high again.
- R8: Acknowledging the vector of an edge-mode external input clears its sticky flag.
- R9: When several sources are qualified, the winner is the first in the order external 0, timer 0, external 1, timer 1, serial.
- R10: After `irq_ack` is sampled high while `irq_req` is high, `irq_req` stays low until a `svc_done` pulse.
- R11: Enable bits 5 and 6 always read 0, and writing 1s to them has no effect.
- R12: The trigger register reads back its two written bits in positions 1:0, and bits 7:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable byte, 1 selects the trigger bits |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| ext_n | input | 2 | Active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer 0 and timer 1 overflow flags |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the winning source |
| irq_ack | input | 1 | Core accepts the current vector |
| svc_done | input | 1 | Core finished the service routine |

## Verification
The main gating and selection path is swept over all 32 per-source enable patterns × both global gate values × all 32 pending patterns, with the external pins in level mode. This separates a wrong bit-to-source mapping, a missing global gate, and a wrong priority order, because each of these produces a different vector or request for some point in the sweep. Every receive/transmit combination is applied to isolate the serial merge.

Directed sequences with pulsed pins tell level behaviour from edge behaviour. They check that an edge is held after the pin rises, that acknowledge clears it, and that a level request held through service reappears only after end-of-service.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_EXT    = 2;
  localparam int NUM_TMR    = 2;
  localparam int NUM_SRC    = NUM_EXT + NUM_TMR + 1;
  localparam int SRC_SERIAL = NUM_SRC - 1;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
  localparam int GATE_BIT   = 7;
  localparam logic SEL_ENABLE = 1'b0;
  localparam logic SEL_TRIG   = 1'b1;

  // Source slot of external input n and timer n (interleaved order).
  function automatic int ext_slot(input int n);
    return 2 * n;
  endfunction

  function automatic int tmr_slot(input int n);
    return 2 * n + 1;
  endfunction
endpackage

// File: rtl/irqc_ext_input.sv
module irqc_ext_input (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic pin_q;
  logic edge_flag;
  logic fall_seen;

  assign fall_seen = pin_q && !pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= 1'b1;
      edge_flag <= 1'b0;
    end else begin
      pin_q <= pin_n;
      if (!edge_mode)     edge_flag <= 1'b0;
      else if (fall_seen) edge_flag <= 1'b1;
      else if (clr)       edge_flag <= 1'b0;
    end
  end

  assign req = edge_mode ? edge_flag : !pin_n;

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && edge_flag && !clr) |=> (edge_flag || !edge_mode)); // R7
  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr && !fall_seen) |=> !edge_flag); // R8
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> (!edge_flag || edge_mode)); // R6
endmodule

// File: rtl/irqc_prio_arb.sv
module irqc_prio_arb #(
  parameter int N     = 5,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     qual,
  output logic             any,
  output logic [N-1:0]     grant,
  output logic [VEC_W-1:0] vec
);
  import irqc_pkg::*;
  localparam int IDX_W = $clog2(N);

  function automatic logic [IDX_W-1:0] first_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(int'(idx) * VEC_STRIDE + VEC_BASE);
  endfunction

  logic [IDX_W-1:0] win_idx;
  assign win_idx = first_set(qual);
  assign any     = |qual;
  assign vec     = vector_of(win_idx);

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant[g] = any && (win_idx == IDX_W'(g));
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> $countones(grant) == 1); // R9
  AST_GRANT_IS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~qual) == '0); // R9
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (vec[2:0] == 3'd3 && vec < VEC_W'(N * VEC_STRIDE))); // R4
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_rx_flag,
  input  logic             ser_tx_flag,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             svc_done
);
  import irqc_pkg::*;

  logic [NUM_SRC-1:0] en_src;
  logic               en_all;
  logic [NUM_EXT-1:0] trig_edge;
  logic [NUM_EXT-1:0] ext_req;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] qualified;
  logic [NUM_SRC-1:0] grant;
  logic               any_qual;
  logic               in_service;
  logic               ack_take;

  // Register port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_src    <= '0;
      en_all    <= 1'b0;
      trig_edge <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_ENABLE) begin
        en_all <= reg_wdata[GATE_BIT];
        en_src <= reg_wdata[NUM_SRC-1:0];
      end else begin
        trig_edge <= reg_wdata[NUM_EXT-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_ENABLE) begin
      reg_rdata[GATE_BIT]     = en_all;
      reg_rdata[NUM_SRC-1:0]  = en_src;
    end else begin
      reg_rdata[NUM_EXT-1:0]  = trig_edge;
    end
  end

  // Source collection
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    irqc_ext_input u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_n[g]),
      .edge_mode (trig_edge[g]),
      .clr       (ack_take && grant[ext_slot(g)]),
      .req       (ext_req[g])
    );
    assign pending[ext_slot(g)] = ext_req[g];
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign pending[tmr_slot(t)] = tmr_ovf[t];
  end

  assign pending[SRC_SERIAL] = ser_rx_flag || ser_tx_flag;

  assign qualified = pending & en_src & {NUM_SRC{en_all}};

  irqc_prio_arb #(.N(NUM_SRC), .VEC_W(VEC_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .qual  (qualified),
    .any   (any_qual),
    .grant (grant),
    .vec   (irq_vec)
  );

  // Service state
  assign irq_req  = any_qual && !in_service;
  assign ack_take = irq_ack && irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_service <= 1'b0;
    else if (ack_take)  in_service <= 1'b1;
    else if (svc_done)  in_service <= 1'b0;
  end

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_all |-> !irq_req); // R2
  AST_SILENT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !irq_req); // R10
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && !svc_done) |=> !irq_req); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_ENABLE) |-> reg_rdata[6:5] == 2'b00); // R11
  AST_SERIAL_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx_flag && en_all && en_src[SRC_SERIAL] && !in_service) |-> irq_req); // R5
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_ovf = '0;
  logic        ser_rx_flag = 1'b0;
  logic        ser_tx_flag = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0;
  logic        svc_done = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_n(ext_n),
    .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .svc_done(svc_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic pulse_done();
    svc_done = 1'b1; tick(); svc_done = 1'b0;
  endtask

  // Expected request/vector from pending pattern and enables (R3, R4, R9)
  function automatic int expect_rv(input int pend, input int en5, input bit gate);
    int q;
    q = gate ? (pend & en5) : 0;
    for (int k = 0; k < 5; k++) if (q[k]) return 'h10000 | (k * 8 + 3);
    return 0;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    int got;
    int ex;
    #12 rst_n = 1'b1;
    tick();
    // R1: reset state
    reg_sel = 1'b0; #0.5;
    check(reg_rdata == 8'h00, "R1", reg_rdata, 0);
    reg_sel = 1'b1; #0.5;
    check(reg_rdata == 8'h00, "R1", reg_rdata, 0);
    check(irq_req == 1'b0, "R1", irq_req, 0);
    reg_sel = 1'b0;

    // R11 / R12 register read-back
    wr(1'b0, 8'hFF);
    #0.5 check(reg_rdata == 8'h9F, "R11", reg_rdata, 'h9F);
    wr(1'b1, 8'hFF);
    reg_sel = 1'b1; #0.5;
    check(reg_rdata == 8'h03, "R12", reg_rdata, 'h03);
    reg_sel = 1'b0;
    wr(1'b1, 8'h00);

    // Sweep: gate x per-source enables x pending (level mode externals)
    for (int gate = 0; gate < 2; gate++) begin
      for (int en5 = 0; en5 < 32; en5++) begin
        wr(1'b0, 8'(gate << 7) | 8'(en5));
        for (int p = 0; p < 32; p++) begin
          ext_n[0]    = ~p[0];
          tmr_ovf[0]  = p[1];
          ext_n[1]    = ~p[2];
          tmr_ovf[1]  = p[3];
          ser_rx_flag = p[4] & p[0];
          ser_tx_flag = p[4] & ~p[0];
          #0.5;
          got = irq_req ? ('h10000 | int'(irq_vec)) : 0;
          ex  = expect_rv(p, en5, gate[0]);
          if (gate == 0) check(got == ex, "R2", got, ex);
          else           check(got == ex, "R3/R4/R9", got, ex);
        end
      end
    end
    ext_n = 2'b11; tmr_ovf = '0; ser_rx_flag = 0; ser_tx_flag = 0;

    // R5: serial merge, all combinations
    wr(1'b0, 8'h90);
    for (int s = 0; s < 4; s++) begin
      ser_rx_flag = s[0]; ser_tx_flag = s[1];
      #0.5;
      check(irq_req == (s != 0), "R5", irq_req, s != 0);
      if (s != 0) check(irq_vec == 16'h0023, "R5", irq_vec, 'h23);
    end
    ser_rx_flag = 0; ser_tx_flag = 0;

    // R6: level mode, not latched
    wr(1'b0, 8'h85);
    ext_n[1] = 1'b0; #0.5;
    check(irq_req && irq_vec == 16'h0013, "R6", irq_vec, 'h13);
    tick();
    ext_n[1] = 1'b1; #0.5;
    check(!irq_req, "R6", irq_req, 0);

    // R7: edge mode sticky
    wr(1'b1, 8'h01);
    ext_n[0] = 1'b0; #0.5;
    check(!irq_req, "R7", irq_req, 0);
    tick();
    check(irq_req && irq_vec == 16'h0003, "R7", irq_vec, 'h3);
    ext_n[0] = 1'b1; tick();
    check(irq_req && irq_vec == 16'h0003, "R7", irq_req, 1);

    // R10 / R8: acknowledge then end-of-service
    pulse_ack();
    check(!irq_req, "R10", irq_req, 0);
    tick();
    check(!irq_req, "R10", irq_req, 0);
    pulse_done();
    check(!irq_req, "R8", irq_req, 0);

    // R10: level request held across service reappears after done
    ext_n[1] = 1'b0; #0.5;
    check(irq_req && irq_vec == 16'h0013, "R6", irq_vec, 'h13);
    tick();
    pulse_ack();
    check(!irq_req, "R10", irq_req, 0);
    tick(); tick();
    check(!irq_req, "R10", irq_req, 0);
    pulse_done();
    check(irq_req && irq_vec == 16'h0013, "R10", irq_vec, 'h13);
    ext_n[1] = 1'b1;

    // R9 with edge pending and timer pending
    wr(1'b0, 8'h87);
    tmr_ovf[0] = 1'b1;
    ext_n[0] = 1'b0; tick(); ext_n[0] = 1'b1; tick();
    check(irq_vec == 16'h0003, "R9", irq_vec, 'h3);
    pulse_ack(); pulse_done();
    check(irq_req && irq_vec == 16'h000B, "R8", irq_vec, 'hB);
    tmr_ovf[0] = 1'b0;

    finished = 1;
    finish_run();
  end
endmodule